// File: doc/BRIEF.md
# Fixed-Priority Interrupt Recognition Unit

This block decides which interrupt an 8-bit processor core services next. Five request lines feed it. One is a critical line that software cannot mask. One is a latched rising-edge line. Two are level lines. The last is a general external request. The core raises a strobe at each instruction boundary. On that strobe the block checks the armed requests and accepts only the highest-priority one. For the four internally vectored lines it reports the winner and that winner's fixed 16-bit vector address.

When the general external request wins, the block instead runs an acknowledge sequence. It holds the acknowledge output high for three consecutive cycles and captures one byte from the data input on each of those cycles. It then presents the collected call instruction: an opcode byte and a 16-bit target address. Software controls a global enable, three per-line mask bits and a clear bit for the edge latch. Saving machine state and executing the handler are left to the surrounding core.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs `take`, `ack`, `call_valid`, `ien` and `ien_saved` go to 0. All three mask bits are set, and both edge latches are cleared.
- R2: Priority runs critical (source code 1), edge line (2), level A (3), level B (4), external (5). When several armed requests meet at a sampling point, only the highest is accepted, and its code appears on `take_src`. `take_src` is 0 when nothing is accepted.
- R3: `take_vec` carries 0x0024 for code 1, 0x003C for code 2, 0x0034 for code 3, 0x002C for code 4, and 0x0000 for code 5 or when nothing is accepted.
- R4: The critical line ignores the masks and `ien`. A rising edge on `crit_req` sets its latch. It is accepted only if that latch is set and `crit_req` is still high at the sampling point. Acceptance clears the latch.
- R5: A rising edge on `edge_req` sets a pending latch. The latch stays set until the line is accepted, or until a mask write with `sw_pend_clr` high clears it. A new edge wins over the clear. The line is armed when the latch is set, `ien` is 1 and mask bit 2 is 0.
- R6: The level lines are not latched. `lvl_a_req` is armed when it is high, `ien` is 1 and mask bit 1 is 0. `lvl_b_req` is armed when it is high, `ien` is 1 and mask bit 0 is 0.
- R7: `ext_req` is gated only by `ien` and is recognised only if it is high at the sampling point.
- R8: Accepting code 5 raises `ack` in the same cycle as `take`, with `ack_idx` = 0. `ack` stays high for exactly three cycles, and `ack_idx` counts 0, 1, 2. On the clock edge that ends each of those cycles, `ack_data` is captured. One cycle later `call_valid` pulses, with `call_op` set to the first byte, `call_addr[7:0]` to the second byte and `call_addr[15:8]` to the third. While `ack` is high, no request is accepted.
- R9: `sw_ien_clr` clears `ien` and `sw_ien_set` sets it, with the clear winning. Accepting any code other than 1 clears `ien`, and this overrides both software inputs. Accepting code 1 copies the prior `ien` into `ien_saved` and leaves `ien` unchanged.
- R10: Acceptance happens only at a clock edge where `boundary` is high. `take` is a one-cycle pulse in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crit_req | input | 1 | Non-maskable critical request |
| edge_req | input | 1 | Rising-edge latched request |
| lvl_a_req | input | 1 | Level request A |
| lvl_b_req | input | 1 | Level request B |
| ext_req | input | 1 | General external request |
| boundary | input | 1 | Instruction-boundary sampling strobe |
| sw_ien_set | input | 1 | Software sets the global enable |
| sw_ien_clr | input | 1 | Software clears the global enable |
| sw_mask_wr | input | 1 | Software mask write strobe |
| sw_mask_val | input | 3 | Mask bits: 2 edge line, 1 level A, 0 level B (1 = masked) |
| sw_pend_clr | input | 1 | With a mask write, clears the edge-line latch |
| ack_data | input | DATA_W | Byte supplied during acknowledge |
| take | output | 1 | Interrupt accepted (one-cycle pulse) |
| take_src | output | 3 | Accepted source code |
| take_vec | output | 16 | Fixed vector of the accepted source |
| ack | output | 1 | Acknowledge for the external request |
| ack_idx | output | $clog2(N_BYTES) | Index of the byte being collected |
| call_valid | output | 1 | Collected call instruction is ready |
| call_op | output | DATA_W | Opcode byte of the call |
| call_addr | output | (N_BYTES-1)*DATA_W | Target address of the call |
| ien | output | 1 | Global enable state |
| ien_saved | output | 1 | Enable state saved at the last critical acceptance |

## Verification
The bench builds the block with its defaults: an 8-bit data byte and a three-byte call. Those values give a 16-bit call address, so every byte position of the collected instruction is visible on the ports and can be checked. A behavioural model runs alongside the design and compares every output on every cycle. The stimulus includes directed cases: pile-ups of simultaneous requests, masked and cleared edge latches, critical pulses that drop before sampling, and a strobe held high through an acknowledge. A long randomised run then covers mixed request, mask and enable traffic.

// File: rtl/irq_ctrl_pkg.sv
// Shared codes and constants for the interrupt recognition unit.
// Source index i (0 = highest priority) reports as code i+1; code 0 means no acceptance.
package irq_ctrl_pkg;

    localparam int NUM_SRC = 5;
    localparam int VEC_W   = 16;
    localparam int MASK_W  = 3;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_CRIT = 3'd1,
        SRC_EDGE = 3'd2,
        SRC_LVLA = 3'd3,
        SRC_LVLB = 3'd4,
        SRC_EXT  = 3'd5
    } irq_src_e;

    // Fixed vector per source index; the external source is vectored by its call bytes.
    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        case (idx)
            0:       return 16'h0024;
            1:       return 16'h003C;
            2:       return 16'h0034;
            3:       return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
// Rising-edge capture latch.
// Assumes din is already synchronous to clk. A new edge wins over a same-cycle clear.
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic clr,
    output logic pend
);

    logic prev_q;

    // Track the previous input level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= din;
    end

    // Set on a rising edge, drop on clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)              pend <= 1'b0;
        else if (din && !prev_q) pend <= 1'b1;
        else if (clr)            pend <= 1'b0;
    end

    AST_PEND_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(din)); // R5

    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> $past(clr)); // R4

endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: index 0 wins. Purely combinational.
// Assumes req bits already include all gating; grant is one-hot or zero.
module irq_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Each stage grants only when no higher-priority request is present.
    for (genvar i = 0; i < N; i++) begin : g_stage
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    assign any = seen[N];

endmodule

// File: rtl/irq_ack_seq.sv
// Acknowledge sequencer for the external request.
// On start, holds ack high for N_BYTES cycles and captures din on each of those edges.
// Then pulses done with the assembled bytes; byte b lives at bytes_o[b*DATA_W +: DATA_W].
// Assumes start is never raised while ack is high.
module irq_ack_seq #(
    parameter int DATA_W  = 8,
    parameter int N_BYTES = 3,
    localparam int IDX_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [DATA_W-1:0]           din,
    output logic                        ack,
    output logic [IDX_W-1:0]            idx,
    output logic                        done,
    output logic [N_BYTES*DATA_W-1:0]   bytes_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_BYTES - 1);

    // Sequence control: start, step through byte slots, finish with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack  <= 1'b0;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                ack <= 1'b1;
                idx <= '0;
            end else if (ack) begin
                if (idx == LAST) begin
                    ack  <= 1'b0;
                    idx  <= '0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // One capture register per byte slot.
    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        logic [DATA_W-1:0] q;
        // Capture the data byte in this slot's acknowledge cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)                           q <= '0;
            else if (ack && idx == IDX_W'(b))     q <= din;
        end
        assign bytes_o[b*DATA_W +: DATA_W] = q;
    end

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ack) && ($past(idx) == LAST)); // R8

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !ack); // R8

    AST_ACK_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack)) |-> (idx == $past(idx) + 1'b1)); // R8

endmodule

// File: rtl/prio_irq_ctrl.sv
// Interrupt recognition unit top.
// Latches edges, gates requests with the masks and global enable, and picks a winner at
// each instruction-boundary strobe. It reports the vector, or for the external line runs
// the call-byte acknowledge sequence. All inputs are assumed synchronous to clk.
module prio_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int N_BYTES = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              crit_req,
    input  logic                              edge_req,
    input  logic                              lvl_a_req,
    input  logic                              lvl_b_req,
    input  logic                              ext_req,
    input  logic                              boundary,
    input  logic                              sw_ien_set,
    input  logic                              sw_ien_clr,
    input  logic                              sw_mask_wr,
    input  logic [2:0]                        sw_mask_val,
    input  logic                              sw_pend_clr,
    input  logic [DATA_W-1:0]                 ack_data,
    output logic                              take,
    output logic [2:0]                        take_src,
    output logic [15:0]                       take_vec,
    output logic                              ack,
    output logic [$clog2(N_BYTES)-1:0]        ack_idx,
    output logic                              call_valid,
    output logic [DATA_W-1:0]                 call_op,
    output logic [(N_BYTES-1)*DATA_W-1:0]     call_addr,
    output logic                              ien,
    output logic                              ien_saved
);

    localparam int IDX_W  = $clog2(N_BYTES);
    localparam int CALL_W = N_BYTES * DATA_W;
    localparam int I_CRIT = 0;
    localparam int I_EDGE = 1;
    localparam int I_LVLA = 2;
    localparam int I_LVLB = 3;
    localparam int I_EXT  = 4;

    logic [MASK_W-1:0]  mask_q;
    logic               ien_q;
    logic               saved_q;
    logic               crit_pend;
    logic               edge_pend;
    logic [NUM_SRC-1:0] armed;
    logic [NUM_SRC-1:0] grant;
    logic               grant_any;
    logic               sample;
    logic [NUM_SRC-1:0] accept;
    logic               acc_any;
    logic               take_q;
    logic [2:0]         src_q;
    logic [VEC_W-1:0]   vec_q;
    logic [2:0]         src_d;
    logic [VEC_W-1:0]   vec_d;
    logic [CALL_W-1:0]  call_bytes;

    // Latch for the non-maskable critical line; cleared when it is accepted.
    irq_edge_latch u_crit_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (crit_req),
        .clr   (accept[I_CRIT]),
        .pend  (crit_pend)
    );

    // Latch for the edge line; cleared on acceptance or by a software clear.
    irq_edge_latch u_edge_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (edge_req),
        .clr   (accept[I_EDGE] | (sw_mask_wr & sw_pend_clr)),
        .pend  (edge_pend)
    );

    // Arm each source with its own gating rule.
    always_comb begin
        armed[I_CRIT] = crit_pend & crit_req;
        armed[I_EDGE] = edge_pend & ien_q & ~mask_q[2];
        armed[I_LVLA] = lvl_a_req & ien_q & ~mask_q[1];
        armed[I_LVLB] = lvl_b_req & ien_q & ~mask_q[0];
        armed[I_EXT]  = ext_req   & ien_q;
    end

    irq_prio_pick #(.N(NUM_SRC)) u_pick (
        .req   (armed),
        .grant (grant),
        .any   (grant_any)
    );

    // Sample only at a boundary, and never while an acknowledge is running.
    assign sample  = boundary & ~ack;
    assign accept  = grant & {NUM_SRC{sample}};
    assign acc_any = grant_any & sample;

    // Translate the granted index to its code and vector.
    always_comb begin
        src_d = SRC_NONE;
        vec_d = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (accept[i]) begin
                src_d = 3'(i + 1);
                vec_d = vec_of(i);
            end
        end
    end

    // Register the acceptance report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            src_q  <= SRC_NONE;
            vec_q  <= '0;
        end else begin
            take_q <= acc_any;
            src_q  <= src_d;
            vec_q  <= vec_d;
        end
    end

    // Software mask register; everything masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          mask_q <= '1;
        else if (sw_mask_wr) mask_q <= sw_mask_val;
    end

    // Global enable: acceptance of a maskable source beats clear, and clear beats set.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ien_q <= 1'b0;
        else if (acc_any && !accept[I_CRIT]) ien_q <= 1'b0;
        else if (sw_ien_clr)                 ien_q <= 1'b0;
        else if (sw_ien_set)                 ien_q <= 1'b1;
    end

    // Keep the enable state seen when the critical line is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)              saved_q <= 1'b0;
        else if (accept[I_CRIT]) saved_q <= ien_q;
    end

    irq_ack_seq #(.DATA_W(DATA_W), .N_BYTES(N_BYTES)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept[I_EXT]),
        .din     (ack_data),
        .ack     (ack),
        .idx     (ack_idx),
        .done    (call_valid),
        .bytes_o (call_bytes)
    );

    assign call_op   = call_bytes[DATA_W-1:0];
    assign call_addr = call_bytes[CALL_W-1:DATA_W];
    assign take      = take_q;
    assign take_src  = src_q;
    assign take_vec  = vec_q;
    assign ien       = ien_q;
    assign ien_saved = saved_q;

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(boundary)); // R10

    AST_MASKABLE_DROPS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_src != SRC_CRIT) |-> !ien); // R9

    AST_CRIT_SAVES_IEN: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_src == SRC_CRIT) |-> (ien_saved == $past(ien))); // R9

    AST_CRIT_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_src == SRC_CRIT) |-> $past(crit_req)); // R4

    AST_EXT_STARTS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_src == SRC_EXT) |-> (ack && ack_idx == '0)); // R8

    AST_NO_TAKE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack)) |-> !take); // R8

    AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(accept)); // R2

endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crit_req = 0, edge_req = 0, lvl_a_req = 0, lvl_b_req = 0, ext_req = 0;
    logic        boundary = 0, sw_ien_set = 0, sw_ien_clr = 0, sw_mask_wr = 0, sw_pend_clr = 0;
    logic [2:0]  sw_mask_val = 3'b000;
    logic [7:0]  ack_data = 8'h00;
    logic        take, ack, call_valid, ien, ien_saved;
    logic [2:0]  take_src;
    logic [15:0] take_vec;
    logic [1:0]  ack_idx;
    logic [7:0]  call_op;
    logic [15:0] call_addr;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done_run = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .crit_req(crit_req), .edge_req(edge_req),
        .lvl_a_req(lvl_a_req), .lvl_b_req(lvl_b_req), .ext_req(ext_req),
        .boundary(boundary), .sw_ien_set(sw_ien_set), .sw_ien_clr(sw_ien_clr),
        .sw_mask_wr(sw_mask_wr), .sw_mask_val(sw_mask_val), .sw_pend_clr(sw_pend_clr),
        .ack_data(ack_data), .take(take), .take_src(take_src), .take_vec(take_vec),
        .ack(ack), .ack_idx(ack_idx), .call_valid(call_valid), .call_op(call_op),
        .call_addr(call_addr), .ien(ien), .ien_saved(ien_saved)
    );

    // ---------------- behavioural reference model ----------------
    int m_ien, m_saved, m_mask, m_epend, m_eprev, m_cpend, m_cprev;
    int m_ack, m_idx, m_cv, m_op, m_addr, m_take, m_src, m_vec;
    int m_byte[3];

    function automatic int vec_for(int code);
        if (code == 1) return 'h24;
        if (code == 2) return 'h3C;
        if (code == 3) return 'h34;
        if (code == 4) return 'h2C;
        return 0;
    endfunction

    always @(posedge clk) begin : model
        int w;
        int nedge;
        if (!rst_n) begin
            m_ien = 0; m_saved = 0; m_mask = 7; m_epend = 0; m_eprev = 0;
            m_cpend = 0; m_cprev = 0; m_ack = 0; m_idx = 0; m_cv = 0;
            m_op = 0; m_addr = 0; m_take = 0; m_src = 0; m_vec = 0;
            m_byte[0] = 0; m_byte[1] = 0; m_byte[2] = 0;
        end else begin
            w = 0;
            m_cv = 0;
            if (m_ack != 0) begin
                m_byte[m_idx] = int'(ack_data);
                if (m_idx == 2) begin
                    m_ack = 0; m_idx = 0; m_cv = 1;
                    m_op = m_byte[0];
                    m_addr = m_byte[2] * 256 + m_byte[1];
                end else m_idx = m_idx + 1;
            end else if (boundary) begin
                if (m_cpend != 0 && crit_req) w = 1;
                else if (m_epend != 0 && m_ien != 0 && m_mask[2] == 0) w = 2;
                else if (lvl_a_req && m_ien != 0 && m_mask[1] == 0) w = 3;
                else if (lvl_b_req && m_ien != 0 && m_mask[0] == 0) w = 4;
                else if (ext_req && m_ien != 0) w = 5;
            end
            nedge = (edge_req && m_eprev == 0) ? 1 : 0;
            if (nedge != 0) m_epend = 1;
            else if (w == 2 || (sw_mask_wr && sw_pend_clr)) m_epend = 0;
            m_eprev = edge_req ? 1 : 0;
            if (crit_req && m_cprev == 0) m_cpend = 1;
            else if (w == 1) m_cpend = 0;
            m_cprev = crit_req ? 1 : 0;
            if (sw_mask_wr) m_mask = int'(sw_mask_val);
            if (w == 1) m_saved = m_ien;
            if (w >= 2) m_ien = 0;
            else if (sw_ien_clr) m_ien = 0;
            else if (sw_ien_set) m_ien = 1;
            if (w == 5) begin m_ack = 1; m_idx = 0; end
            m_take = (w != 0) ? 1 : 0;
            m_src = w;
            m_vec = vec_for(w);
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (!done_run) begin
            chk("R10 take", int'(take), m_take);
            chk("R2 take_src", int'(take_src), m_src);
            chk("R3 take_vec", int'(take_vec), m_vec);
            chk("R8 ack", int'(ack), m_ack);
            chk("R8 ack_idx", int'(ack_idx), m_idx);
            chk("R8 call_valid", int'(call_valid), m_cv);
            if (m_cv != 0) begin
                chk("R8 call_op", int'(call_op), m_op);
                chk("R8 call_addr", int'(call_addr), m_addr);
            end
            chk("R9 ien", int'(ien), m_ien);
            chk("R9 ien_saved", int'(ien_saved), m_saved);
        end
    end

    // Watchdog.
    initial begin
        #1500000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic sw_enable();
        sw_ien_set = 1; tick(); sw_ien_set = 0;
    endtask

    task automatic sw_mask(input logic [2:0] v, input logic clr);
        sw_mask_wr = 1; sw_mask_val = v; sw_pend_clr = clr; tick();
        sw_mask_wr = 0; sw_pend_clr = 0;
    endtask

    task automatic strobe();
        boundary = 1; tick(); boundary = 0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) tick();
        chk("R1 take", int'(take), 0);
        chk("R1 ack", int'(ack), 0);
        chk("R1 ien", int'(ien), 0);
        chk("R1 call_valid", int'(call_valid), 0);
        rst_n = 1;
        tick();
        // R1: all masks set after reset, so an enabled level request is refused
        sw_enable();
        lvl_b_req = 1; strobe(); lvl_b_req = 0;
        chk("R1 masked after reset", int'(take), 0);

        // R2: simultaneous level A, level B, external -> level A wins
        sw_mask(3'b000, 0);
        lvl_a_req = 1; lvl_b_req = 1; ext_req = 1; strobe();
        chk("R2 winner", int'(take_src), 3);
        chk("R3 level A vector", int'(take_vec), 'h34);
        chk("R9 ien dropped", int'(ien), 0);
        lvl_a_req = 0; lvl_b_req = 0; ext_req = 0;

        // R6: mask level A; level B wins
        sw_enable(); sw_mask(3'b010, 0);
        lvl_a_req = 1; lvl_b_req = 1; strobe();
        chk("R6 masked A, B taken", int'(take_src), 4);
        chk("R3 level B vector", int'(take_vec), 'h2C);
        lvl_a_req = 0; lvl_b_req = 0;
        // R6: level pulse gone before strobe is not remembered
        sw_enable(); lvl_b_req = 1; tick(); lvl_b_req = 0; tick(); strobe();
        chk("R6 not latched", int'(take), 0);

        // R5: edge latched and taken later
        sw_mask(3'b000, 0);
        edge_req = 1; tick(); edge_req = 0; repeat (3) tick(); strobe();
        chk("R5 latched edge taken", int'(take_src), 2);
        chk("R3 edge vector", int'(take_vec), 'h3C);
        // R5: masked edge stays pending, then taken when unmasked
        sw_enable(); sw_mask(3'b100, 0);
        edge_req = 1; tick(); edge_req = 0; strobe();
        chk("R5 masked edge refused", int'(take), 0);
        sw_mask(3'b000, 0); strobe();
        chk("R5 pending edge taken", int'(take_src), 2);
        // R5: software clear drops the pending edge
        sw_enable(); sw_mask(3'b100, 0);
        edge_req = 1; tick(); edge_req = 0; tick();
        sw_mask(3'b000, 1); strobe();
        chk("R5 cleared edge", int'(take), 0);

        // R4: critical line ignores disable and masks
        sw_ien_clr = 1; tick(); sw_ien_clr = 0; sw_mask(3'b111, 0);
        crit_req = 1; tick(); strobe();
        chk("R4 critical taken", int'(take_src), 1);
        chk("R3 critical vector", int'(take_vec), 'h24);
        chk("R9 saved disabled", int'(ien_saved), 0);
        strobe();
        chk("R4 held level no retake", int'(take), 0);
        crit_req = 0; tick();
        crit_req = 1; tick(); crit_req = 0; tick(); strobe();
        chk("R4 dropped before sample", int'(take), 0);
        sw_enable(); crit_req = 1; tick(); strobe();
        chk("R4 critical taken again", int'(take_src), 1);
        chk("R9 saved enabled", int'(ien_saved), 1);
        chk("R9 ien kept", int'(ien), 1);
        crit_req = 0; tick();

        // R7: external refused while disabled
        sw_ien_clr = 1; tick(); sw_ien_clr = 0;
        ext_req = 1; strobe();
        chk("R7 disabled external", int'(take), 0);
        // R8: acknowledge sequence collects a call
        sw_enable(); sw_mask(3'b000, 0); strobe();
        chk("R7 external taken", int'(take_src), 5);
        chk("R8 ack raised", int'(ack), 1);
        ext_req = 0; boundary = 1; lvl_a_req = 1;
        ack_data = 8'hCD; tick();
        chk("R8 no take during ack", int'(take), 0);
        ack_data = 8'h34; tick();
        ack_data = 8'h12; tick();
        boundary = 0; lvl_a_req = 0;
        chk("R8 call ready", int'(call_valid), 1);
        chk("R8 opcode", int'(call_op), 'hCD);
        chk("R8 address", int'(call_addr), 'h1234);
        chk("R8 ack done", int'(ack), 0);

        // R10: requests without a strobe are not taken
        sw_enable(); lvl_a_req = 1; repeat (3) tick(); lvl_a_req = 0;
        chk("R10 no strobe", int'(take), 0);

        // Mixed random traffic checked against the model each cycle.
        for (int n = 0; n < 4000; n++) begin
            crit_req   = ($urandom_range(0, 15) == 0) ? ~crit_req : crit_req;
            edge_req   = ($urandom_range(0, 5) == 0);
            lvl_a_req  = ($urandom_range(0, 7) == 0);
            lvl_b_req  = ($urandom_range(0, 7) == 0);
            ext_req    = ($urandom_range(0, 5) == 0);
            boundary   = ($urandom_range(0, 2) == 0);
            sw_ien_set = ($urandom_range(0, 3) == 0);
            sw_ien_clr = ($urandom_range(0, 11) == 0);
            sw_mask_wr = ($urandom_range(0, 15) == 0);
            sw_mask_val = 3'($urandom_range(0, 7));
            sw_pend_clr = ($urandom_range(0, 3) == 0);
            ack_data   = 8'($urandom_range(0, 255));
            tick();
        end
        done_run = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule